// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor that keeps a single working register, the accumulator, and one shared memory for both code and data. Each instruction is a 16-bit word whose top four bits pick the operation and whose low twelve bits hold an address or an unsigned immediate. A control state machine takes every instruction through a fixed series of register transfers:

- a fetch through the address and data registers;
- a decode of the operation field only;
- an execute sequence chosen per instruction;
- a return to the next fetch.

The fetched word stays in its own instruction register, so the execute steps can reuse the memory data register freely.

Memory sits outside the core. It is synchronous, with one clock of read latency. The core always presents its memory address register on the address pins and raises a single-cycle write strobe for stores. A data input port feeds the input instruction. An output port carries a value together with a one-cycle valid pulse. A halt instruction parks the core until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high on a clock edge, every register clears to zero. After that edge `out_valid`, `halted` and `mem_we` are 0 and `mem_addr` is 0, so the first instruction after reset is fetched from address 0.
- R2: Each fetch reads the word at the current program counter and then adds 1 to the counter, so instructions without a jump run from consecutive addresses.
- R3: Opcode 0 (jump) loads the low 12 bits of the instruction into the program counter without touching memory. The next fetch comes from that address.
- R4: Opcode 1 (input) captures `in_data` into the data register and then copies it into the accumulator.
- R5: Opcode 2 (load) places the low 12-bit field in the address register and reads that word. The word then goes through the data register into the accumulator.
- R6: Opcode 3 (store) places the field in the address register and copies the accumulator into the data register. It then raises `mem_we` for exactly one cycle, with `mem_wdata` equal to the accumulator.
- R7: Opcode 4 (add immediate) zero-extends the 12-bit field into the data register and adds it to the accumulator, modulo 2^16.
- R8: Opcode 5 (add memory) reads the word at the field address and adds it to the accumulator, modulo 2^16.
- R9: Opcode 6 (output accumulator) drives the accumulator on `out_data` with `out_valid` high for exactly one cycle.
- R10: Opcode 7 (output memory) reads the word at the field address and presents it on `out_data` with a one-cycle `out_valid` pulse. The accumulator is left unchanged.
- R11: Opcodes 8 to 14 act as no-operations. The accumulator and memory stay unchanged and execution continues with the next address.
- R12: Opcode 15 (halt) sets `halted` and holds it until reset. While halted the core raises no write strobe and no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | WORD_W | Value taken by the input instruction |
| mem_rdata | input | WORD_W | Memory read data, one clock after the address |
| mem_addr | output | WORD_W-4 | Memory address (the address register) |
| mem_wdata | output | WORD_W | Memory write data (the data register) |
| mem_we | output | 1 | Single-cycle memory write strobe |
| out_data | output | WORD_W | Output value |
| out_valid | output | 1 | One-cycle pulse marking `out_data` |
| halted | output | 1 | High after a halt instruction until reset |

## Verification
The bench builds the core with its default `WORD_W` of 16, which gives a 12-bit address field. It places a 256-word memory model beside the core, so only the low eight address bits pick a word. At this width an add of 0xF000 to 0x2233 carries out of bit 15, so the modulo wrap of the accumulator can be observed. The largest immediate, 0xFFF, shows that the field is zero-extended. Two programs are run with a reset between them and different `in_data` values. The outputs are compared in order against a queue of expected values. A jump skips over a word that would produce an extra output, and a halt is followed by a word that must never run.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_JMP  = 4'd0,
        OP_IN   = 4'd1,
        OP_LDM  = 4'd2,
        OP_STO  = 4'd3,
        OP_ADDI = 4'd4,
        OP_ADDM = 4'd5,
        OP_OUTA = 4'd6,
        OP_OUTM = 4'd7,
        OP_HALT = 4'd15
    } opcode_e;

    typedef enum logic [3:0] {
        S_F_ADDR,
        S_F_WAIT,
        S_F_CAP,
        S_F_CIR,
        S_DECODE,
        S_X_JMP,
        S_X_IN,
        S_X_MAR,
        S_X_WAIT,
        S_X_CAP,
        S_X_IMM,
        S_X_ACC2MDR,
        S_X_WRITE,
        S_X_FIN,
        S_X_OUTA,
        S_HALT
    } state_e;

    typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_FIELD} mar_sel_e;
    typedef enum logic [2:0] {MDR_HOLD, MDR_MEM, MDR_IN, MDR_IMM, MDR_ACC} mdr_sel_e;
    typedef enum logic [1:0] {ACC_HOLD, ACC_MDR, ACC_SUM} acc_sel_e;
    typedef enum logic [1:0] {OUT_NONE, OUT_ACC, OUT_MDR} out_sel_e;

    typedef struct packed {
        mar_sel_e mar_sel;
        mdr_sel_e mdr_sel;
        acc_sel_e acc_sel;
        out_sel_e out_sel;
        logic     pc_inc;
        logic     pc_jump;
        logic     cir_load;
        logic     mem_we;
    } ctrl_t;

    // First execute state for a decoded operation field
    function automatic state_e exec_entry(input logic [OPC_W-1:0] op);
        state_e nxt;
        case (op)
            OP_JMP:                           nxt = S_X_JMP;
            OP_IN:                            nxt = S_X_IN;
            OP_LDM, OP_STO, OP_ADDM, OP_OUTM: nxt = S_X_MAR;
            OP_ADDI:                          nxt = S_X_IMM;
            OP_OUTA:                          nxt = S_X_OUTA;
            OP_HALT:                          nxt = S_HALT;
            default:                          nxt = S_F_ADDR;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/acc_cpu_adder.sv
module acc_cpu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Carry out is dropped: result wraps modulo 2^W
    assign y = a + b;
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OPC_W-1:0]     opcode,
    output ctrl_t                ctrl,
    output state_e               state,
    output logic                 halted
);
    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_F_ADDR;
        else     state_q <= state_d;
    end

    always_comb begin
        ctrl    = '0;
        state_d = state_q;
        case (state_q)
            S_F_ADDR: begin
                ctrl.mar_sel = MAR_PC;
                state_d      = S_F_WAIT;
            end
            S_F_WAIT: begin
                ctrl.pc_inc = 1'b1;
                state_d     = S_F_CAP;
            end
            S_F_CAP: begin
                ctrl.mdr_sel = MDR_MEM;
                state_d      = S_F_CIR;
            end
            S_F_CIR: begin
                ctrl.cir_load = 1'b1;
                state_d       = S_DECODE;
            end
            S_DECODE: begin
                state_d = exec_entry(opcode);
            end
            S_X_JMP: begin
                ctrl.pc_jump = 1'b1;
                state_d      = S_F_ADDR;
            end
            S_X_IN: begin
                ctrl.mdr_sel = MDR_IN;
                state_d      = S_X_FIN;
            end
            S_X_MAR: begin
                ctrl.mar_sel = MAR_FIELD;
                state_d      = (opcode == OP_STO) ? S_X_ACC2MDR : S_X_WAIT;
            end
            S_X_WAIT: begin
                state_d = S_X_CAP;
            end
            S_X_CAP: begin
                ctrl.mdr_sel = MDR_MEM;
                state_d      = S_X_FIN;
            end
            S_X_IMM: begin
                ctrl.mdr_sel = MDR_IMM;
                state_d      = S_X_FIN;
            end
            S_X_ACC2MDR: begin
                ctrl.mdr_sel = MDR_ACC;
                state_d      = S_X_WRITE;
            end
            S_X_WRITE: begin
                ctrl.mem_we = 1'b1;
                state_d     = S_F_ADDR;
            end
            S_X_FIN: begin
                case (opcode)
                    OP_IN, OP_LDM:    ctrl.acc_sel = ACC_MDR;
                    OP_ADDI, OP_ADDM: ctrl.acc_sel = ACC_SUM;
                    OP_OUTM:          ctrl.out_sel = OUT_MDR;
                    default:          ;
                endcase
                state_d = S_F_ADDR;
            end
            S_X_OUTA: begin
                ctrl.out_sel = OUT_ACC;
                state_d      = S_F_ADDR;
            end
            S_HALT: begin
                state_d = S_HALT;
            end
            default: state_d = S_F_ADDR;
        endcase
    end

    assign state  = state_q;
    assign halted = (state_q == S_HALT);
endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W  = 16,
    localparam int FIELD_W = WORD_W - OPC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic [WORD_W-1:0]  in_data,
    input  logic [WORD_W-1:0]  sum,
    output logic [FIELD_W-1:0] pc,
    output logic [FIELD_W-1:0] mar,
    output logic [WORD_W-1:0]  mdr,
    output logic [WORD_W-1:0]  cir,
    output logic [WORD_W-1:0]  acc,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_valid
);
    logic [FIELD_W-1:0] field;
    assign field = cir[FIELD_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            mar       <= '0;
            mdr       <= '0;
            cir       <= '0;
            acc       <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            case (ctrl.mar_sel)
                MAR_PC:    mar <= pc;
                MAR_FIELD: mar <= field;
                default:   ;
            endcase

            case (ctrl.mdr_sel)
                MDR_MEM: mdr <= mem_rdata;
                MDR_IN:  mdr <= in_data;
                MDR_IMM: mdr <= {{OPC_W{1'b0}}, field};
                MDR_ACC: mdr <= acc;
                default: ;
            endcase

            if (ctrl.pc_jump)     pc <= field;
            else if (ctrl.pc_inc) pc <= pc + 1'b1;

            if (ctrl.cir_load) cir <= mdr;

            case (ctrl.acc_sel)
                ACC_MDR: acc <= mdr;
                ACC_SUM: acc <= sum;
                default: ;
            endcase

            out_valid <= (ctrl.out_sel != OUT_NONE);
            case (ctrl.out_sel)
                OUT_ACC: out_data <= acc;
                OUT_MDR: out_data <= mdr;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W  = 16,
    localparam int FIELD_W = WORD_W - OPC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_W-1:0]  in_data,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [FIELD_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               mem_we,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_valid,
    output logic               halted
);
    ctrl_t              ctrl_w;
    state_e             state_q;
    logic [FIELD_W-1:0] pc_q;
    logic [FIELD_W-1:0] mar_q;
    logic [WORD_W-1:0]  mdr_q;
    logic [WORD_W-1:0]  cir_q;
    logic [WORD_W-1:0]  acc_q;
    logic [WORD_W-1:0]  sum_w;
    logic [OPC_W-1:0]   opcode_w;
    logic [FIELD_W-1:0] field_w;

    assign opcode_w = cir_q[WORD_W-1 -: OPC_W];
    assign field_w  = cir_q[FIELD_W-1:0];

    acc_cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode_w),
        .ctrl   (ctrl_w),
        .state  (state_q),
        .halted (halted)
    );

    acc_cpu_adder #(.W(WORD_W)) u_adder (
        .a (acc_q),
        .b (mdr_q),
        .y (sum_w)
    );

    acc_cpu_regs #(.WORD_W(WORD_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_w),
        .mem_rdata (mem_rdata),
        .in_data   (in_data),
        .sum       (sum_w),
        .pc        (pc_q),
        .mar       (mar_q),
        .mdr       (mdr_q),
        .cir       (cir_q),
        .acc       (acc_q),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign mem_we    = ctrl_w.mem_we;
endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W  = 16,
    localparam int FIELD_W = WORD_W - OPC_W
) (
    input logic               clk,
    input logic               rst,
    input state_e             state,
    input logic [FIELD_W-1:0] pc,
    input logic [FIELD_W-1:0] field,
    input logic               mem_we,
    input logic               out_valid,
    input logic               halted
);
    // R2: the fetch wait step advances the counter by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_F_WAIT) |=> (pc == $past(pc) + 1'b1));

    // R3: the jump step loads the instruction field into the counter
    assert_jump_target_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_X_JMP) |=> (pc == $past(field)));

    // R6: a store writes for a single cycle
    assert_write_single_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R9: output strobe is a one-cycle pulse
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R12: halt holds until reset
    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R12: nothing is written or output while halted
    assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_we && !out_valid));
endmodule

bind acc_cpu_core acc_cpu_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state_q),
    .pc        (pc_q),
    .field     (field_w),
    .mem_we    (mem_we),
    .out_valid (out_valid),
    .halted    (halted)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 16;
    localparam int FIELD_W    = WORD_W - 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [WORD_W-1:0]  in_data = '0;
    logic [WORD_W-1:0]  mem_rdata;
    logic [FIELD_W-1:0] mem_addr;
    logic [WORD_W-1:0]  mem_wdata;
    logic               mem_we;
    logic [WORD_W-1:0]  out_data;
    logic               out_valid;
    logic               halted;

    int n_checks = 0;
    int n_err    = 0;

    logic [WORD_W-1:0] exp_q[$];
    string             tag_q[$];

    // bench memory model with a load port
    logic [WORD_W-1:0] mem [256];
    logic              ld_en = 1'b0;
    logic [7:0]        ld_addr = '0;
    logic [WORD_W-1:0] ld_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    acc_cpu_core #(.WORD_W(WORD_W)) i_acc_cpu_core (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .out_data  (out_data),
        .out_valid (out_valid),
        .halted    (halted)
    );

    function automatic logic [WORD_W-1:0] ins(input logic [3:0] op, input logic [11:0] f);
        return {op, f};
    endfunction

    task automatic check(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [WORD_W-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // driver: push an expected output onto the scoreboard
    task automatic expect_out(input logic [WORD_W-1:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic reset_checks(input string req);
        check({req, " out_valid"}, {15'd0, out_valid}, 16'd0);
        check({req, " halted"},    {15'd0, halted},    16'd0);
        check({req, " mem_we"},    {15'd0, mem_we},    16'd0);
        check({req, " mem_addr"},  {4'd0, mem_addr},   16'd0);
    endtask

    task automatic wait_halt(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (halted) begin seen = 1'b1; break; end
        end
        check({req, " halted reached"}, {15'd0, seen}, 16'd1);
    endtask

    // monitor: pop and compare as outputs appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R9 unexpected output actual=%h expected=none", out_data);
            end else begin
                logic [WORD_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_data !== e) begin
                    n_err++;
                    $display("FAIL %s output actual=%h expected=%h", t, out_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        // ---------- program A, loaded during reset ----------
        in_data = 16'h1234;
        poke(8'h00, ins(4'd1, 12'h000));   // input
        poke(8'h01, ins(4'd6, 12'h000));   // out acc
        poke(8'h02, ins(4'd3, 12'h080));   // store 0x80
        poke(8'h03, ins(4'd4, 12'hFFF));   // add imm 0xFFF
        poke(8'h04, ins(4'd6, 12'h000));
        poke(8'h05, ins(4'd5, 12'h081));   // add mem 0x81
        poke(8'h06, ins(4'd6, 12'h000));
        poke(8'h07, ins(4'd2, 12'h080));   // load 0x80
        poke(8'h08, ins(4'd6, 12'h000));
        poke(8'h09, ins(4'd9, 12'hABC));   // undefined
        poke(8'h0A, ins(4'd6, 12'h000));
        poke(8'h0B, ins(4'd7, 12'h082));   // out mem 0x82
        poke(8'h0C, ins(4'd6, 12'h000));
        poke(8'h0D, ins(4'd0, 12'h020));   // jump 0x20
        poke(8'h0E, ins(4'd6, 12'h000));   // skipped
        poke(8'h20, ins(4'd3, 12'h083));   // store 0x83
        poke(8'h21, ins(4'd15, 12'h000));  // halt
        poke(8'h22, ins(4'd6, 12'h000));   // never runs
        poke(8'h81, 16'hF000);
        poke(8'h82, 16'hBEEF);
        poke(8'h83, 16'h0000);
        poke(8'h84, 16'h5A5A);

        @(negedge clk);
        reset_checks("R1 initial");

        expect_out(16'h1234, "R4 input");
        expect_out(16'h2233, "R7 add immediate zero-extended");
        expect_out(16'h1233, "R8 add memory wraps");
        expect_out(16'h1234, "R5 load after R6 store");
        expect_out(16'h1234, "R11 undefined opcode no-op");
        expect_out(16'hBEEF, "R10 output memory");
        expect_out(16'h1234, "R10 accumulator unchanged");

        rst = 1'b0;
        wait_halt("R12 program A");
        repeat (40) @(negedge clk);
        check("R12 halted held", {15'd0, halted}, 16'd1);
        check("R3 R12 scoreboard drained", exp_q.size(), 16'd0);
        check("R6 store 0x80", mem[8'h80], 16'h1234);
        check("R3 store after jump 0x83", mem[8'h83], 16'h1234);
        check("R11 memory untouched 0x84", mem[8'h84], 16'h5A5A);

        // ---------- program B after a reset from halt ----------
        rst = 1'b1;
        in_data = 16'h00FF;
        poke(8'h00, ins(4'd1, 12'h000));   // input
        poke(8'h01, ins(4'd5, 12'h081));   // add mem F000
        poke(8'h02, ins(4'd6, 12'h000));
        poke(8'h03, ins(4'd4, 12'h001));   // add imm 1
        poke(8'h04, ins(4'd6, 12'h000));
        poke(8'h05, ins(4'd15, 12'h000));
        @(negedge clk);
        reset_checks("R1 after halt");

        expect_out(16'hF0FF, "R2 R4 R8 program B");
        expect_out(16'hF100, "R2 R7 program B");
        rst = 1'b0;
        wait_halt("R12 program B");
        repeat (20) @(negedge clk);
        check("R2 scoreboard drained B", exp_q.size(), 16'd0);
        check("R12 halted held B", {15'd0, halted}, 16'd1);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule